// File: doc/BRIEF.md
# Instruction Sequencer with Two-Deep Return Stack

This block steps through a 512-word instruction store. It keeps a 9-bit program counter and a return stack that holds two 9-bit entries. It also runs a four-clock instruction-cycle timer. The decoder sits outside the block and tells the sequencer the class of the instruction at the current fetch address. It also supplies that instruction's literal field and, for register writes to the counter, an 8-bit data byte. The counter changes only at the end of an instruction cycle. The block drives the fetch address, a readable low byte of the counter, and a strobe that marks the last clock of each cycle.

A change of flow costs a second instruction cycle. Goto, call, return and counter writes all count as a change of flow, and so does a taken skip. The block marks that second cycle as a bubble, and the decoder must treat the bubble cycle as a no-operation. Call and counter writes can only reach the lower half of the store, because they clear bit 8. The stack still saves full 9-bit return addresses. A return also pulses a load request so that the literal goes to the working register outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: An instruction cycle is four clocks. `cyc_strobe` is high in the fourth clock only. The counter and the stack change only at the clock edge that ends a strobe clock.
- R2: While synchronous reset is high, the counter is set to 0x1FF, the phase to the first clock, both stack entries to 0 and the bubble flag to 0.
- R3: A sequential instruction (`op_kind` 0, or any code 5 to 7) advances the counter by one, modulo 512, so 0x1FF goes to 0x000.
- R4: A call (`op_kind` 2) pushes the counter plus one as a full 9-bit value. It then loads `op_lit[7:0]` with bit 8 cleared, so `op_lit[8]` has no effect.
- R5: The stack holds two entries. A push onto a full stack moves the top entry down and drops the older one. A pop returns the top entry and leaves the bottom entry as it was, so extra returns repeat the last address.
- R6: A counter write (`op_kind` 4) loads `wr_data` with bit 8 cleared. `pc_low` always equals bits 7..0 of the fetch address.
- R7: A return (`op_kind` 3) loads the top stack entry into the counter. In its strobe clock it raises `w_load`, with `w_lit` equal to `op_lit[7:0]`.
- R8: After a goto, call, return or counter write, the next instruction cycle is a bubble and the counter holds the target. After a taken skip, the next cycle is a bubble and the counter advances by one, so two addresses are passed.
- R9: In a bubble cycle, `op_kind`, `op_lit`, `wr_data` and `skip_req` have no effect, and `w_load` stays low.
- R10: A goto (`op_kind` 1) loads all nine bits of `op_lit`.
- R11: `skip_req` acts only together with a sequential class. A flow instruction with `skip_req` high behaves as if `skip_req` were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 3 | Class of the current instruction: 0 seq, 1 goto, 2 call, 3 return, 4 counter write |
| op_lit | input | 9 | Literal field of the current instruction |
| wr_data | input | 8 | Byte written to the counter by a register write |
| skip_req | input | 1 | Skip condition is true for the current instruction |
| fetch_addr | output | 9 | Address of the instruction store word being fetched |
| pc_low | output | 8 | Readable low byte of the counter |
| cyc_strobe | output | 1 | High in the last clock of each instruction cycle |
| bubble | output | 1 | The current cycle is a discarded (no-operation) cycle |
| w_load | output | 1 | Return literal is to be written to the working register |
| w_lit | output | 8 | Literal passed to the working register |

## Verification
A push and the loss of the oldest entry can fall in the same cycle. The bench provokes this by issuing a call onto a full stack from an address in the upper half, where bit 8 of the saved return address differs from that of the target. It then judges the result by the addresses that later returns produce. Two other cases fall on the same edge: a flow instruction with `skip_req` high, and a goto presented during a bubble cycle. For each, the bench compares the fetch address after the edge against a behavioural model. This shows which function won and that the bubble cycle ignored its inputs.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        K_SEQ  = 3'd0,
        K_GOTO = 3'd1,
        K_CALL = 3'd2,
        K_RET  = 3'd3,
        K_PCWR = 3'd4
    } kind_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic load_w;
        logic start_bubble;
        logic bubble_holds;
    } step_ctl_t;

    function automatic logic is_flow(logic [2:0] k);
        return (k == K_GOTO) || (k == K_CALL) || (k == K_RET) || (k == K_PCWR);
    endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int CW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
    end

    assign strobe = (cnt == LAST);

    // R1: strobe lasts a single clock and restarts the count
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
    p_strobe_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (cnt == '0));

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    logic [W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    ent[g] <= '0;
                else if (push)
                    ent[g] <= din;
                else if (pop && DEPTH > 1)
                    ent[g] <= ent[(DEPTH > 1) ? 1 : 0];
            end
        end else if (g == DEPTH - 1) begin : g_tail
            // oldest slot: overwritten on push, kept on pop
            always_ff @(posedge clk) begin
                if (rst)
                    ent[g] <= '0;
                else if (push)
                    ent[g] <= ent[g-1];
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)
                    ent[g] <= '0;
                else if (push)
                    ent[g] <= ent[g-1];
                else if (pop)
                    ent[g] <= ent[g+1];
            end
        end
    end

    assign top = ent[0];

    // R5: a push lands on top; a pop never disturbs the oldest slot
    p_push_top_r5: assert property (@(posedge clk) disable iff (rst)
        push |=> (top == $past(din)));
    p_pop_keeps_oldest_r5: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> $stable(ent[DEPTH-1]));
    p_no_dual_op_r5: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/seq_next_pc.sv
module seq_next_pc
    import seq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [2:0]        op_kind,
    input  logic [ADDR_W-1:0] op_lit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              skip_req,
    input  logic              in_bubble,
    input  logic              bubble_hold,
    input  logic [ADDR_W-1:0] stack_top,
    output logic [ADDR_W-1:0] pc_nxt,
    output logic [ADDR_W-1:0] ret_addr,
    output step_ctl_t         ctl
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] low_target;
    logic [ADDR_W-1:0] data_target;

    assign pc_inc      = pc + {{(ADDR_W-1){1'b0}}, 1'b1};
    assign low_target  = {{HI_W{1'b0}}, op_lit[DATA_W-1:0]};
    assign data_target = {{HI_W{1'b0}}, wr_data};
    assign ret_addr    = pc_inc;

    always_comb begin
        ctl    = '0;
        pc_nxt = pc_inc;
        if (in_bubble) begin
            pc_nxt = bubble_hold ? pc : pc_inc;
        end else begin
            case (op_kind)
                K_GOTO: pc_nxt = op_lit;
                K_CALL: begin
                    pc_nxt   = low_target;
                    ctl.push = 1'b1;
                end
                K_RET: begin
                    pc_nxt     = stack_top;
                    ctl.pop    = 1'b1;
                    ctl.load_w = 1'b1;
                end
                K_PCWR: pc_nxt = data_target;
                default: pc_nxt = pc_inc;
            endcase
            if (is_flow(op_kind)) begin
                ctl.start_bubble = 1'b1;
                ctl.bubble_holds = 1'b1;
            end else if (skip_req) begin
                ctl.start_bubble = 1'b1;
                ctl.bubble_holds = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W = seq_pkg::ADDR_W,
    parameter int DATA_W = seq_pkg::DATA_W,
    parameter int DEPTH  = 2,
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_kind,
    input  logic [ADDR_W-1:0] op_lit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              skip_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] pc_low,
    output logic              cyc_strobe,
    output logic              bubble,
    output logic              w_load,
    output logic [DATA_W-1:0] w_lit
);
    localparam logic [ADDR_W-1:0] RESET_PC = {ADDR_W{1'b1}};

    logic              strobe;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] stack_top;
    logic              bubble_q;
    logic              hold_q;
    step_ctl_t         ctl;

    seq_phase_timer #(.PHASES(PHASES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe)
    );

    seq_next_pc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_next (
        .pc          (pc_q),
        .op_kind     (op_kind),
        .op_lit      (op_lit),
        .wr_data     (wr_data),
        .skip_req    (skip_req),
        .in_bubble   (bubble_q),
        .bubble_hold (hold_q),
        .stack_top   (stack_top),
        .pc_nxt      (pc_nxt),
        .ret_addr    (ret_addr),
        .ctl         (ctl)
    );

    seq_ret_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (strobe && ctl.push),
        .pop  (strobe && ctl.pop),
        .din  (ret_addr),
        .top  (stack_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            bubble_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (strobe) begin
            pc_q     <= pc_nxt;
            bubble_q <= ctl.start_bubble;
            hold_q   <= ctl.bubble_holds;
        end
    end

    assign fetch_addr = pc_q;
    assign pc_low     = pc_q[DATA_W-1:0];
    assign cyc_strobe = strobe;
    assign bubble     = bubble_q;
    assign w_load     = strobe && ctl.load_w;
    assign w_lit      = op_lit[DATA_W-1:0];

    // R2: reset vector
    p_reset_vector_r2: assert property (@(posedge clk)
        rst |=> (fetch_addr == RESET_PC && !bubble));
    // R1: counter only moves at the end of a strobe clock
    p_pc_steady_r1: assert property (@(posedge clk) disable iff (rst)
        !cyc_strobe |=> $stable(fetch_addr));
    // R4: a call always lands in the lower half
    p_call_low_half_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc_strobe && !bubble && op_kind == K_CALL) |=> !fetch_addr[ADDR_W-1]);
    // R9: a bubble lasts exactly one instruction cycle and never loads W
    p_bubble_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc_strobe && bubble) |=> !bubble);
    p_bubble_no_wload_r9: assert property (@(posedge clk) disable iff (rst)
        bubble |-> !w_load);
    // R10: goto reaches all nine bits
    p_goto_full_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc_strobe && !bubble && op_kind == K_GOTO) |=> (fetch_addr == $past(op_lit)));

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_SEQ = 3'd0, C_GOTO = 3'd1, C_CALL = 3'd2,
                           C_RET = 3'd3, C_PCWR = 3'd4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_kind = C_SEQ;
    logic [8:0] op_lit = '0;
    logic [7:0] wr_data = '0;
    logic       skip_req = 1'b0;
    logic [8:0] fetch_addr;
    logic [7:0] pc_low;
    logic       cyc_strobe, bubble, w_load;
    logic [7:0] w_lit;

    int n_checks = 0;
    int n_fails  = 0;
    bit model_on = 0;
    bit finished = 0;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst(rst), .op_kind(op_kind), .op_lit(op_lit),
        .wr_data(wr_data), .skip_req(skip_req), .fetch_addr(fetch_addr),
        .pc_low(pc_low), .cyc_strobe(cyc_strobe), .bubble(bubble),
        .w_load(w_load), .w_lit(w_lit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_pc, m_ph, m_bub, m_hold;
    int stk[$];

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 511; m_ph = 0; m_bub = 0; m_hold = 0;
            stk = '{0, 0};
        end else begin
            if (m_ph == 3) begin
                if (m_bub != 0) begin
                    if (m_hold == 0) m_pc = (m_pc + 1) % 512;
                    m_bub = 0;
                end else begin
                    case (op_kind)
                        C_GOTO: begin m_pc = op_lit; m_bub = 1; m_hold = 1; end
                        C_CALL: begin
                            stk.push_front((m_pc + 1) % 512);
                            if (stk.size() > 2) void'(stk.pop_back());
                            m_pc = op_lit & 255; m_bub = 1; m_hold = 1;
                        end
                        C_RET: begin
                            m_pc = stk.pop_front();
                            stk.push_back(stk[stk.size()-1]);
                            m_bub = 1; m_hold = 1;
                        end
                        C_PCWR: begin m_pc = wr_data; m_bub = 1; m_hold = 1; end
                        default: begin
                            m_pc = (m_pc + 1) % 512;
                            if (skip_req) begin m_bub = 1; m_hold = 0; end
                        end
                    endcase
                end
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    // per-clock comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (model_on && !finished) begin
            check("R3", fetch_addr, m_pc, "fetch_addr vs model");
            check("R6", pc_low, m_pc & 255, "pc_low vs model");
            check("R1", cyc_strobe, (m_ph == 3), "cyc_strobe vs model");
            check("R8", bubble, m_bub, "bubble vs model");
            check("R7", w_load, (m_ph == 3 && m_bub == 0 && op_kind == C_RET), "w_load vs model");
            if (w_load) check("R7", w_lit, op_lit & 255, "w_lit");
        end
    end

    task automatic run_cycle(logic [2:0] k, logic [8:0] lit, logic [7:0] d, logic s);
        op_kind = k; op_lit = lit; wr_data = d; skip_req = s;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_pc(string tag, int exp, string what);
        check(tag, fetch_addr, exp, what);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", fetch_addr, 9'h1FF, "reset fetch address");
        check("R2", cyc_strobe, 0, "reset strobe");
        check("R2", bubble, 0, "reset bubble");
        rst = 1'b0;
        model_on = 1;

        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        expect_pc("R3", 9'h000, "wrap from top address");

        run_cycle(C_GOTO, 9'h150, 8'h00, 1'b0);
        expect_pc("R10", 9'h150, "goto nine-bit target");
        run_cycle(C_GOTO, 9'h010, 8'h00, 1'b1);     // bubble: ignored
        expect_pc("R9", 9'h150, "goto inside bubble ignored");

        // nested calls two deep, then an overflowing third
        run_cycle(C_CALL, 9'h020, 8'h00, 1'b0);
        expect_pc("R4", 9'h020, "first call");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_CALL, 9'h040, 8'h00, 1'b0);
        expect_pc("R4", 9'h040, "second call");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_CALL, 9'h060, 8'h00, 1'b0);
        expect_pc("R5", 9'h060, "third call overflows");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_RET, 9'h05A, 8'h00, 1'b0);
        expect_pc("R7", 9'h041, "return from third call");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_RET, 9'h011, 8'h00, 1'b0);
        expect_pc("R5", 9'h021, "return to second frame");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_RET, 9'h022, 8'h00, 1'b0);
        expect_pc("R5", 9'h021, "extra return repeats bottom");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);

        run_cycle(C_CALL, 9'h1AB, 8'h00, 1'b0);
        expect_pc("R4", 9'h0AB, "call clears bit 8");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);

        // call from the upper half saves a full return address
        run_cycle(C_GOTO, 9'h1F0, 8'h00, 1'b0);
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_CALL, 9'h033, 8'h00, 1'b0);
        expect_pc("R4", 9'h033, "call from upper half");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_RET, 9'h000, 8'h00, 1'b0);
        expect_pc("R4", 9'h1F1, "return to upper half");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);

        run_cycle(C_PCWR, 9'h000, 8'hC3, 1'b0);
        expect_pc("R6", 9'h0C3, "counter write clears bit 8");
        check("R6", pc_low, 8'hC3, "low byte readback");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        expect_pc("R8", 9'h0C3, "bubble holds write target");

        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b1);
        expect_pc("R8", 9'h0C4, "taken skip advances");
        check("R8", bubble, 1, "skip opens bubble");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        expect_pc("R8", 9'h0C5, "skipped slot advances");

        run_cycle(C_GOTO, 9'h100, 8'h00, 1'b1);
        expect_pc("R11", 9'h100, "skip with goto: goto wins");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        expect_pc("R11", 9'h100, "held target after goto+skip");

        // overflow and upper-half call on the same edge
        run_cycle(C_GOTO, 9'h180, 8'h00, 1'b0);
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_CALL, 9'h010, 8'h00, 1'b0);
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_RET, 9'h000, 8'h00, 1'b0);
        expect_pc("R5", 9'h181, "return after overflow from upper half");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        run_cycle(C_RET, 9'h000, 8'h00, 1'b0);
        expect_pc("R5", 9'h022, "surviving older entry");
        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);

        run_cycle(C_SEQ, 9'h000, 8'h00, 1'b0);
        expect_pc("R3", 9'h023, "plain increment");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule